// File: doc/BRIEF.md
# Host Bus Capture and Write Strobe Generator

This block sits between a slow 6502-style expansion bus and a fast asynchronous SRAM or flash part. On some hosts the address, data and direction lines stop being valid before the bus clock (PHI2) falls. Logic that trusts those lines up to the falling edge then sees corrupted values. This block avoids that. It oversamples PHI2 with a fast local clock and captures the bus lines early in the high phase. It then drives the memory only from those frozen copies.

Address, direction and device-select are frozen at the detected PHI2 rise. Write data is frozen a fixed number of local cycles later. The memory write-enable is built from the synchronized rise, not from the whole PHI2-high window. It has one of two shapes, chosen by a parameter. The counted shape starts at the rise and lasts a programmed number of local cycles. The default width is the smallest cycle count that covers 100 ns. The gated shape is the synchronized PHI2 ANDed with a copy of itself delayed by a programmed number of cycles. Both shapes end when PHI2 goes low. The read enable for the memory follows the frozen select and direction while PHI2 is high.

Top module: `hostbus_capture`

## Requirements
- R1: PHI2 passes through a two-stage synchronizer on the local clock. The captured outputs change on the third local rising edge that samples PHI2 high, and not before.
- R2: The captured address, direction (1 = read, 0 = write) and select come from the bus at the detected rise. They are held unchanged until the next detected rise, whatever the bus lines do later in that PHI2 cycle.
- R3: The captured data is taken DATA_AT local cycles after the capture edge, while PHI2 is still high. It then holds, so changes in the last part of the high phase are ignored.
- R4: In counted mode, a write cycle (select = 1, direction = 0 at the rise) raises `wr_strobe` on the capture edge. The strobe stays high for WE_CYCLES local cycles when PHI2 stays high at least that long.
- R5: `wr_strobe` is forced low two local edges after PHI2 is first sampled low, even when the count has not run out. In counted mode, a PHI2-high phase of H samples therefore gives a strobe of min(WE_CYCLES, H) cycles.
- R6: A read cycle or a deselected cycle produces no strobe. At most one strobe pulse is produced per PHI2 cycle.
- R7: `rd_enable` is high from the capture edge of a selected read cycle until `wr_strobe` would be cut (R5). It is never high together with `wr_strobe`.
- R8: In gated mode, a write cycle with H high samples gives one strobe of max(H − DLY_CYCLES, 0) cycles. The strobe starts DLY_CYCLES cycles after the capture edge and ends as in R5.
- R9: Synchronous reset clears every captured value and holds both `wr_strobe` and `rd_enable` low, including during a pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| phi2_in | input | 1 | Asynchronous host bus clock |
| addr_in | input | ADDR_W | Host address lines |
| data_in | input | DATA_W | Host write data lines |
| rnw_in | input | 1 | Host direction, 1 = read |
| sel_in | input | 1 | Device-select decode, 1 = selected |
| cap_addr | output | ADDR_W | Frozen address for the memory |
| cap_data | output | DATA_W | Frozen write data for the memory |
| cap_rnw | output | 1 | Frozen direction |
| cap_sel | output | 1 | Frozen select |
| wr_strobe | output | 1 | Memory write enable, active high |
| rd_enable | output | 1 | Memory output enable, active high |

## Verification
A synchronizer stage that is lost or added moves every capture and strobe edge by one local cycle. This shows at the very first bus cycle. A capture register that follows the bus instead of holding would take up the corrupted values driven in the last 30 ns of PHI2 high. That shows at the ports within the same PHI2 cycle. A strobe counter or cut-off that is off by one changes the measured pulse length for that write. A missing cut would keep a short-phase write strobe running into PHI2 low.

// File: rtl/hostbus_capture_pkg.sv
package hostbus_capture_pkg;

    // Shape of the memory write strobe
    typedef enum logic {
        STB_COUNT = 1'b0,   // fixed counted width from the rise
        STB_AND   = 1'b1    // synchronized PHI2 gated by its delayed copy
    } stb_mode_e;

    // Synchronized view of the bus clock
    typedef struct packed {
        logic hi;    // PHI2 after two synchronizer stages
        logic rise;  // one-cycle flag on the first high sample
    } phase_t;

    // Smallest local cycle count covering a time span
    function automatic int ns_to_cycles(input int ns, input int mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

    // Counter width able to hold the value n
    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/hostbus_phi_sync.sv
module hostbus_phi_sync
    import hostbus_capture_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   phi2_in,
    output phase_t ph
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= phi2_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        ph.hi   = sync_q;
        ph.rise = sync_q & ~prev_q;
    end

endmodule

// File: rtl/hostbus_bus_hold.sv
module hostbus_bus_hold
    import hostbus_capture_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int DATA_AT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_t            ph,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              rnw_in,
    input  logic              sel_in,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data,
    output logic              cap_rnw,
    output logic              cap_sel,
    output logic              rd_enable
);

    localparam int PH_W = cnt_bits(DATA_AT + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rnw;
        logic              sel;
    } hdr_t;

    hdr_t              hdr_q;
    logic [DATA_W-1:0] data_q;
    logic [PH_W-1:0]   age_q;
    logic              oe_q;

    // Address, direction and select frozen at the detected rise
    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q <= '0;
        end else if (ph.rise) begin
            hdr_q <= '{addr: addr_in, rnw: rnw_in, sel: sel_in};
        end
    end

    // Age of the current high phase, saturating past the data sample point
    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (ph.rise) begin
            age_q <= PH_W'(1);
        end else if (!ph.hi) begin
            age_q <= '0;
        end else if (age_q != '0 && age_q <= PH_W'(DATA_AT)) begin
            age_q <= age_q + PH_W'(1);
        end
    end

    // Write data frozen once, DATA_AT cycles into the high phase
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (ph.hi && age_q == PH_W'(DATA_AT)) begin
            data_q <= data_in;
        end
    end

    // Memory output enable for selected reads
    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q <= 1'b0;
        end else if (ph.rise) begin
            oe_q <= sel_in & rnw_in;
        end else if (!ph.hi) begin
            oe_q <= 1'b0;
        end
    end

    assign cap_addr  = hdr_q.addr;
    assign cap_rnw   = hdr_q.rnw;
    assign cap_sel   = hdr_q.sel;
    assign cap_data  = data_q;
    assign rd_enable = oe_q;

endmodule

// File: rtl/hostbus_strobe_count.sv
module hostbus_strobe_count
    import hostbus_capture_pkg::*;
#(
    parameter int WE_CYCLES = 10
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_t ph,
    input  logic   wr_req,
    output logic   strobe
);

    localparam int REM_W = cnt_bits(WE_CYCLES);

    logic [REM_W-1:0] rem_q;
    logic             on_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q  <= 1'b0;
            rem_q <= '0;
        end else if (ph.rise) begin
            on_q  <= wr_req;
            rem_q <= REM_W'(WE_CYCLES - 1);
        end else if (!ph.hi) begin
            on_q  <= 1'b0;
        end else if (on_q) begin
            if (rem_q == '0) begin
                on_q <= 1'b0;
            end else begin
                rem_q <= rem_q - REM_W'(1);
            end
        end
    end

    assign strobe = on_q;

endmodule

// File: rtl/hostbus_strobe_and.sv
module hostbus_strobe_and
    import hostbus_capture_pkg::*;
#(
    parameter int DLY_CYCLES = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_t ph,
    input  logic   wr_req,
    output logic   strobe
);

    logic [DLY_CYCLES-1:0] hist_q;
    logic                  armed_q;
    logic                  on_q;

    // Delayed copy of the synchronized PHI2
    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            hist_q[0] <= ph.hi;
            for (int i = 1; i < DLY_CYCLES; i++) begin
                hist_q[i] <= hist_q[i-1];
            end
        end
    end

    // Write decision taken at the rise, dropped in the low phase
    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (ph.rise) begin
            armed_q <= wr_req;
        end else if (!ph.hi) begin
            armed_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q <= 1'b0;
        end else begin
            on_q <= armed_q & ph.hi & hist_q[DLY_CYCLES-1];
        end
    end

    assign strobe = on_q;

endmodule

// File: rtl/hostbus_capture.sv
module hostbus_capture
    import hostbus_capture_pkg::*;
#(
    parameter int        ADDR_W     = 16,
    parameter int        DATA_W     = 8,
    parameter int        CLK_MHZ    = 100,
    parameter int        WE_NS      = 100,
    parameter int        WE_CYCLES  = ns_to_cycles(WE_NS, CLK_MHZ),
    parameter int        DATA_AT    = 3,
    parameter int        DLY_CYCLES = 3,
    parameter stb_mode_e MODE       = STB_COUNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phi2_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              rnw_in,
    input  logic              sel_in,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data,
    output logic              cap_rnw,
    output logic              cap_sel,
    output logic              wr_strobe,
    output logic              rd_enable
);

    phase_t ph;
    logic   wr_req;

    assign wr_req = sel_in & ~rnw_in;

    hostbus_phi_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .phi2_in (phi2_in),
        .ph      (ph)
    );

    hostbus_bus_hold #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .DATA_AT (DATA_AT)
    ) u_hold (
        .clk       (clk),
        .rst       (rst),
        .ph        (ph),
        .addr_in   (addr_in),
        .data_in   (data_in),
        .rnw_in    (rnw_in),
        .sel_in    (sel_in),
        .cap_addr  (cap_addr),
        .cap_data  (cap_data),
        .cap_rnw   (cap_rnw),
        .cap_sel   (cap_sel),
        .rd_enable (rd_enable)
    );

    generate
        if (MODE == STB_AND) begin : g_and
            hostbus_strobe_and #(
                .DLY_CYCLES (DLY_CYCLES)
            ) u_stb (
                .clk    (clk),
                .rst    (rst),
                .ph     (ph),
                .wr_req (wr_req),
                .strobe (wr_strobe)
            );
        end else begin : g_count
            hostbus_strobe_count #(
                .WE_CYCLES (WE_CYCLES)
            ) u_stb (
                .clk    (clk),
                .rst    (rst),
                .ph     (ph),
                .wr_req (wr_req),
                .strobe (wr_strobe)
            );
        end
    endgenerate

endmodule

// File: rtl/hostbus_capture_chk.sv
module hostbus_capture_chk
    import hostbus_capture_pkg::*;
#(
    parameter int        ADDR_W    = 16,
    parameter int        WE_CYCLES = 10,
    parameter stb_mode_e MODE      = STB_COUNT
) (
    input logic              clk,
    input logic              rst,
    input logic              ph_hi,
    input logic              ph_rise,
    input logic [ADDR_W-1:0] cap_addr,
    input logic              cap_rnw,
    input logic              cap_sel,
    input logic              wr_strobe,
    input logic              rd_enable
);

    int run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= 0;
        end else if (wr_strobe) begin
            run_len <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    // R6
    strobe_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> (cap_sel && !cap_rnw));

    // R7
    oe_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_enable |-> (cap_sel && cap_rnw && !wr_strobe));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ph_rise |=> $stable(cap_addr));

    // R5
    strobe_cut_chk: assert property (@(posedge clk) disable iff (rst)
        !ph_hi |=> !wr_strobe);

    generate
        if (MODE == STB_COUNT) begin : g_len
            // R4
            strobe_len_chk: assert property (@(posedge clk) disable iff (rst)
                run_len <= WE_CYCLES);
        end
    endgenerate

endmodule

bind hostbus_capture hostbus_capture_chk #(
    .ADDR_W    (ADDR_W),
    .WE_CYCLES (WE_CYCLES),
    .MODE      (MODE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ph_hi     (ph.hi),
    .ph_rise   (ph.rise),
    .cap_addr  (cap_addr),
    .cap_rnw   (cap_rnw),
    .cap_sel   (cap_sel),
    .wr_strobe (wr_strobe),
    .rd_enable (rd_enable)
);

// File: tb/hostbus_capture_bench.sv
module hostbus_capture_bench;
    import hostbus_capture_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;
    localparam int DW         = 8;
    localparam int WE_CYC     = 10;
    localparam int DATA_AT    = 3;
    localparam int DLY        = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          phi2 = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] d_in = '0;
    logic          rnw = 1'b1;
    logic          sel = 1'b0;

    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_data, b_data;
    logic          a_rnw, a_sel, a_we, a_oe;
    logic          b_rnw, b_sel, b_we, b_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostbus_capture #(
        .ADDR_W (AW), .DATA_W (DW), .CLK_MHZ (100), .WE_NS (100),
        .DATA_AT (DATA_AT), .DLY_CYCLES (DLY), .MODE (STB_COUNT)
    ) u_hostbus_capture (
        .clk (clk), .rst (rst), .phi2_in (phi2), .addr_in (addr),
        .data_in (d_in), .rnw_in (rnw), .sel_in (sel),
        .cap_addr (a_addr), .cap_data (a_data), .cap_rnw (a_rnw),
        .cap_sel (a_sel), .wr_strobe (a_we), .rd_enable (a_oe)
    );

    hostbus_capture #(
        .ADDR_W (AW), .DATA_W (DW), .CLK_MHZ (100), .WE_NS (100),
        .DATA_AT (DATA_AT), .DLY_CYCLES (DLY), .MODE (STB_AND)
    ) u_hostbus_capture_and (
        .clk (clk), .rst (rst), .phi2_in (phi2), .addr_in (addr),
        .data_in (d_in), .rnw_in (rnw), .sel_in (sel),
        .cap_addr (b_addr), .cap_data (b_data), .cap_rnw (b_rnw),
        .cap_sel (b_sel), .wr_strobe (b_we), .rd_enable (b_oe)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    bit          m_s1, m_s2, m_s3;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_data;
    bit          m_rnw, m_sel, m_we, m_oe, m_arm, m_we2;
    int          m_ph, m_rem;
    bit          dq[$];

    always @(posedge clk) begin
        bit rise, dl;
        rise = m_s2 && !m_s3;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_addr = '0; m_data = '0; m_rnw = 0; m_sel = 0;
            m_we = 0; m_oe = 0; m_arm = 0; m_we2 = 0; m_ph = 0; m_rem = 0;
            dq.delete();
            repeat (DLY) dq.push_back(1'b0);
        end else begin
            dl = dq.pop_front();
            dq.push_back(m_s2);
            m_we2 = m_arm && m_s2 && dl;
            if (rise) m_arm = sel && !rnw;
            else if (!m_s2) m_arm = 0;
            if (m_s2 && m_ph == DATA_AT) m_data = d_in;
            if (rise) m_ph = 1;
            else if (!m_s2) m_ph = 0;
            else if (m_ph != 0 && m_ph <= DATA_AT) m_ph++;
            if (rise) begin
                m_addr = addr; m_rnw = rnw; m_sel = sel;
            end
            if (rise) begin
                m_we = sel && !rnw; m_rem = WE_CYC - 1;
            end else if (!m_s2) begin
                m_we = 0;
            end else if (m_we) begin
                if (m_rem == 0) m_we = 0;
                else m_rem--;
            end
            if (rise) m_oe = sel && rnw;
            else if (!m_s2) m_oe = 0;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = phi2;
        end
    end

    // Per-cycle comparison and pulse measurement, away from the active edge
    int  len_a = 0, len_b = 0, rises_a = 0;
    bit  a_we_prev = 0;

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 cap_addr", a_addr, m_addr);
            chk("R2 cap_rnw", a_rnw, m_rnw);
            chk("R2 cap_sel", a_sel, m_sel);
            chk("R3 cap_data", a_data, m_data);
            chk("R4 wr_strobe", a_we, m_we);
            chk("R7 rd_enable", a_oe, m_oe);
            chk("R8 wr_strobe gated", b_we, m_we2);
            if (a_we) len_a++;
            if (a_we && !a_we_prev) rises_a++;
            a_we_prev = a_we;
            if (b_we) len_b++;
        end
    end

    task automatic bus_cycle(input logic [AW-1:0] a, input logic [DW-1:0] dv,
                             input logic r, input logic s, input int hi, input int lo,
                             input bit check_r1);
        logic [AW-1:0] old_addr;
        bit            wr;
        int            exp_b;
        @(negedge clk);
        wr = s && !r;
        old_addr = a_addr;
        len_a = 0; len_b = 0; rises_a = 0;
        addr = a; d_in = dv; rnw = r; sel = s; phi2 = 1'b1;
        for (int i = 0; i < hi; i++) begin
            @(negedge clk);
            if (check_r1 && i == 1) chk("R1 before third edge", a_addr, old_addr);
            if (check_r1 && i == 2) chk("R1 on third edge", a_addr, a);
            if (hi >= 3 && i == hi - 1) chk("R7 enable in high phase", a_oe, s && r);
            if (hi >= 12 && i == hi - 4) begin
                addr = ~a; d_in = ~dv; rnw = ~r; sel = ~s;
            end
        end
        phi2 = 1'b0;
        repeat (lo) @(negedge clk);
        chk("R2 address held", a_addr, a);
        chk("R2 direction held", a_rnw, r);
        chk("R2 select held", a_sel, s);
        if (hi >= DATA_AT + 1) chk("R3 data held", a_data, dv);
        chk("R4 R5 strobe length", len_a, wr ? ((hi < WE_CYC) ? hi : WE_CYC) : 0);
        chk("R6 pulse count", rises_a, wr ? 1 : 0);
        exp_b = (wr && hi > DLY) ? hi - DLY : 0;
        chk("R8 gated length", len_b, exp_b);
    endtask

    initial begin
        int seed;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 state after reset
        chk("R9 addr after reset", a_addr, 0);
        chk("R9 data after reset", a_data, 0);
        chk("R9 strobe after reset", a_we, 0);
        chk("R9 enable after reset", a_oe, 0);

        bus_cycle(16'h1234, 8'hA5, 1'b0, 1'b1, 28, 28, 1'b1);
        bus_cycle(16'hBEEF, 8'h3C, 1'b1, 1'b1, 28, 28, 1'b1);
        bus_cycle(16'h0F0F, 8'h77, 1'b0, 1'b0, 28, 28, 1'b1);
        bus_cycle(16'h4321, 8'h11, 1'b0, 1'b1, 6, 20, 1'b1);
        bus_cycle(16'h8000, 8'hFF, 1'b0, 1'b1, 10, 10, 1'b0);
        bus_cycle(16'h8001, 8'h00, 1'b0, 1'b1, 3, 10, 1'b0);
        bus_cycle(16'hFFFF, 8'h5A, 1'b0, 1'b1, 40, 16, 1'b0);

        seed = 32'h1F2E3D4C;
        for (int n = 0; n < 24; n++) begin
            seed = seed * 1103515245 + 12345;
            bus_cycle(AW'(seed >> 8), DW'(seed >> 3), seed[20], seed[21] | seed[22],
                      3 + ((seed >>> 16) & 31), 6 + ((seed >>> 24) & 7), 1'b0);
        end

        // R9 reset during a running strobe
        @(negedge clk);
        addr = 16'h2222; d_in = 8'h44; rnw = 1'b0; sel = 1'b1; phi2 = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 strobe running", a_we, 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 strobe cleared by reset", a_we, 0);
        chk("R9 address cleared by reset", a_addr, 0);
        phi2 = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        bus_cycle(16'h5555, 8'h99, 1'b0, 1'b1, 28, 28, 1'b1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule